// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked user port and an external asynchronous static RAM of 256K words by 16 bits. Each user request carries an address, a read/write flag, write data and one select bit per byte. The controller turns it into the strobe sequence the memory needs. All phase lengths are whole clock cycles. Each one is derived at elaboration time from a clock-period parameter and the memory's minimum and maximum times, rounded up, with a floor of one cycle.

Writes are made with output enable held high for the whole access, which allows the shorter of the two write-pulse minimums. The controller drives the data bus only when the memory's outputs cannot be on. When a read follows directly on a write, the controller inserts one extra cycle with every strobe inactive before it lowers output enable. When no request is pending, chip enable stays high and the memory sits in standby.

The user holds `req` and the request fields steady until `ready` pulses. For a read, `rdata` is valid from the `ready` cycle onwards.

Top module: `sram_seq_ctrl`

## Requirements
- R1: A write asserts chip enable in a setup cycle and then holds write enable low for the computed pulse length, which is 2 cycles at the default 4 ns clock. Output enable stays high throughout. `ready` pulses 4 cycles after the request is accepted from idle.
- R2: `bsel[0]` selects the low byte (data bits 7:0, `sram_be_n[0]`) and `bsel[1]` selects the high byte (bits 15:8, `sram_be_n[1]`). On a write, only selected lanes have their byte enable low and their driver on. An unselected byte keeps its previous memory content.
- R3: A read holds chip enable and output enable low, with write enable high, for the computed access time, which is 3 cycles by default. It samples the bus at the end of the last access cycle and returns that word on `rdata` with `ready`, 4 cycles after acceptance.
- R4: In returned read data, a byte whose `bsel` bit is 0 reads as zero.
- R5: A data driver turns on only while output enable is high and was already high in the previous cycle. It is never on while the memory is driving. All drivers are off in the cycle in which write enable returns high.
- R6: A read that is requested in the first idle cycle after a write completes gets one extra cycle with all strobes inactive, which gives a latency of 5. If at least one idle cycle without a request passes first, the read latency stays 4.
- R7: While idle with no request, chip enable, write enable, output enable and both byte enables are high, and no driver is on.
- R8: `ready` is high for exactly one cycle per accepted request.
- R9: During and directly after synchronous reset the block is idle: all strobes are inactive, no driver is on and `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request pending; held until `ready` |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| bsel | input | 2 | Byte select, bit 0 low byte, bit 1 high byte |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read word, unselected bytes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Byte enables, active low, bit 0 low byte |
| dq_out | output | 16 | Data to memory |
| dq_oe | output | 2 | Per-byte driver enable |
| dq_in | input | 16 | Data from memory |

## Verification
Assertions check the bus-safety rules on every cycle:
- output enable stays high while write enable is low;
- drivers are never on while output enable is low, and only turn on after output enable has been high for a cycle;
- drivers are released as write enable rises;
- the write pulse reaches its minimum length;
- output enable only falls out of an inactive cycle;
- `ready` is a single-cycle pulse;
- unselected read bytes come back as zero.

Only the bench scenarios can show the rest. These are the exact latencies, the extra turnaround cycle that depends on how soon a read follows a write, and whether masked writes leave the other byte intact in a memory model. The bench model also refuses data that is sampled before the access time has elapsed.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WSET = 3'd1,
        ST_WPUL = 3'd2,
        ST_TURN = 3'd3,
        ST_RACC = 3'd4,
        ST_DONE = 3'd5
    } sram_st_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic act;
        logic wphase;
    } strobe_t;

    function automatic int cycles_for(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t decode(input sram_st_e s);
        strobe_t r;
        case (s)
            ST_WSET: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, act: 1'b1, wphase: 1'b1};
            ST_WPUL: r = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, act: 1'b1, wphase: 1'b1};
            ST_RACC: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, act: 1'b1, wphase: 1'b0};
            default: r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, act: 1'b0, wphase: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // R1: every timed phase lasts at least one cycle
    a_r1_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       sel_in,
    input  logic [7:0] wbyte_in,
    input  logic       act,
    input  logic       wphase,
    input  logic       cap,
    input  logic [7:0] din,
    output logic       be_n,
    output logic       doe,
    output logic [7:0] dout,
    output logic [7:0] rbyte
);

    logic       sel_q;
    logic [7:0] w_q;
    logic [7:0] r_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            w_q   <= '0;
            r_q   <= '0;
        end else begin
            if (load) begin
                sel_q <= sel_in;
                w_q   <= wbyte_in;
            end
            if (cap) begin
                r_q <= sel_q ? din : 8'h00;
            end
        end
    end

    assign be_n  = !(act && sel_q);
    assign doe   = wphase && sel_q;
    assign dout  = w_q;
    assign rbyte = r_q;

    // R4: an unselected byte returns zero
    a_r4_unselected_zero: assert property (@(posedge clk) disable iff (rst)
        (cap && !sel_q) |=> (rbyte == 8'h00));

    // R3: a selected byte returns the bus value sampled at the end of access
    a_r3_selected_capture: assert property (@(posedge clk) disable iff (rst)
        (cap && sel_q) |=> (rbyte == $past(din)));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int AW       = 18,
    parameter int DW       = 16,
    parameter int CLK_PS   = 4000,
    parameter int T_RC_PS  = 10000,
    parameter int T_AA_PS  = 10000,
    parameter int T_WC_PS  = 10000,
    parameter int T_WP_PS  = 8000,
    parameter int T_DS_PS  = 5000,
    parameter int T_AS_PS  = 0,
    parameter int TW       = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/8-1:0] bsel,
    output logic            ready,
    output logic [DW-1:0]   rdata,
    output logic [AW-1:0]   sram_addr,
    output logic            sram_ce_n,
    output logic            sram_we_n,
    output logic            sram_oe_n,
    output logic [DW/8-1:0] sram_be_n,
    output logic [DW-1:0]   dq_out,
    output logic [DW/8-1:0] dq_oe,
    input  logic [DW-1:0]   dq_in
);

    localparam int NB      = DW / 8;
    localparam int SET_CYC = cycles_for(T_AS_PS, CLK_PS);
    localparam int WP_CYC  = imax(imax(cycles_for(T_WP_PS, CLK_PS), cycles_for(T_DS_PS, CLK_PS)),
                                  imax(cycles_for(T_WC_PS, CLK_PS) - SET_CYC, 1));
    localparam int RD_CYC  = imax(cycles_for(T_AA_PS, CLK_PS), cycles_for(T_RC_PS, CLK_PS));
    localparam logic [TW-1:0] SET_V = TW'(SET_CYC);
    localparam logic [TW-1:0] WP_V  = TW'(WP_CYC);
    localparam logic [TW-1:0] RD_V  = TW'(RD_CYC);

    sram_st_e      st_q, st_d;
    strobe_t       stb;
    logic          tload;
    logic [TW-1:0] tval;
    logic          tlast;
    logic          accept;
    logic          cap;
    logic [AW-1:0] addr_q;
    logic          wr_q;
    logic          last_wr_q;

    always_comb begin
        st_d  = st_q;
        tload = 1'b0;
        tval  = '0;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    if (wr) begin
                        st_d  = ST_WSET;
                        tload = 1'b1;
                        tval  = SET_V;
                    end else if (last_wr_q) begin
                        st_d  = ST_TURN;
                    end else begin
                        st_d  = ST_RACC;
                        tload = 1'b1;
                        tval  = RD_V;
                    end
                end
            end
            ST_WSET: begin
                if (tlast) begin
                    st_d  = ST_WPUL;
                    tload = 1'b1;
                    tval  = WP_V;
                end
            end
            ST_WPUL: begin
                if (tlast) st_d = ST_DONE;
            end
            ST_TURN: begin
                st_d  = ST_RACC;
                tload = 1'b1;
                tval  = RD_V;
            end
            ST_RACC: begin
                if (tlast) st_d = ST_DONE;
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign accept = (st_q == ST_IDLE) && req;
    assign cap    = (st_q == ST_RACC) && tlast;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            addr_q    <= '0;
            wr_q      <= 1'b0;
            last_wr_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                addr_q <= addr;
                wr_q   <= wr;
            end
            if (st_q == ST_DONE) begin
                last_wr_q <= wr_q;
            end else if ((st_q == ST_IDLE && !req) || st_q == ST_TURN) begin
                last_wr_q <= 1'b0;
            end
        end
    end

    sram_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tload),
        .load_val (tval),
        .last     (tlast)
    );

    assign stb = decode(st_q);

    for (genvar g = 0; g < NB; g++) begin : g_lane
        sram_byte_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .load     (accept),
            .sel_in   (bsel[g]),
            .wbyte_in (wdata[8*g +: 8]),
            .act      (stb.act),
            .wphase   (stb.wphase),
            .cap      (cap),
            .din      (dq_in[8*g +: 8]),
            .be_n     (sram_be_n[g]),
            .doe      (dq_oe[g]),
            .dout     (dq_out[8*g +: 8]),
            .rbyte    (rdata[8*g +: 8])
        );
    end

    assign sram_addr = addr_q;
    assign sram_ce_n = stb.ce_n;
    assign sram_we_n = stb.we_n;
    assign sram_oe_n = stb.oe_n;
    assign ready     = (st_q == ST_DONE);

    // checker state: length of the current write-enable low run
    logic [7:0] we_lo_cnt;
    always_ff @(posedge clk) begin
        if (rst)             we_lo_cnt <= '0;
        else if (!sram_we_n) we_lo_cnt <= (we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1;
        else                 we_lo_cnt <= '0;
    end

    // R1: output enable stays high and the chip is selected while writing
    a_r1_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n));

    // R1: the write pulse reaches its minimum length
    a_r1_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_lo_cnt >= 8'(WP_CYC)));

    // R5: no driver while the memory may be driving
    a_r5_no_drive_oe_low: assert property (@(posedge clk) disable iff (rst)
        (|dq_oe) |-> sram_oe_n);

    // R5: drivers come on only after output enable has been high a cycle
    a_r5_drive_after_oe_high: assert property (@(posedge clk) disable iff (rst)
        $rose(|dq_oe) |-> $past(sram_oe_n));

    // R5: drivers are released as write enable rises
    a_r5_release_on_we_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (dq_oe == '0));

    // R6: output enable only falls out of a cycle with the chip deselected
    a_r6_oe_fall_from_inactive: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_oe_n) |-> $past(sram_ce_n));

    // R7: idle means standby with no lane enabled
    a_r7_idle_standby: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> (sram_ce_n && (&sram_be_n) && dq_oe == '0));

    // R8: ready is a single-cycle pulse
    a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        req;
    logic        wr;
    logic [17:0] addr;
    logic [15:0] wdata;
    logic [1:0]  bsel;
    logic        ready;
    logic [15:0] rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n;
    logic [1:0]  sram_be_n;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [15:0] dq_in;

    sram_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
        .bsel(bsel), .ready(ready), .rdata(rdata), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_be_n(sram_be_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem_m [int];
    logic [15:0] ref_m [int];

    function automatic logic [15:0] init_w(input int a);
        logic [31:0] v;
        v = a;
        return v[15:0] ^ 16'h3C3C;
    endfunction

    function automatic logic [15:0] mem_rd(input int a);
        if (mem_m.exists(a)) return mem_m[a];
        return init_w(a);
    endfunction

    function automatic logic [15:0] ref_rd(input int a);
        if (ref_m.exists(a)) return ref_m[a];
        return init_w(a);
    endfunction

    int          wlow = 0;
    int          rdc = 0;
    int          p_addr;
    logic [15:0] p_data;
    logic [1:0]  p_mask;
    logic        prev_oe_n = 1'b1;

    initial dq_in = 16'hDEAD;

    always @(negedge clk) begin
        if (!rst) begin
            logic [15:0] w;
            if (!sram_ce_n && sram_we_n && !sram_oe_n && sram_be_n != 2'b11 && dq_oe != 2'b00)
                chk(1'b0, "R5", "driver on while memory drives", dq_oe, 0);
            if (dq_oe != 2'b00)
                chk(prev_oe_n && sram_oe_n, "R5", "driver without oe high twice",
                    {prev_oe_n, sram_oe_n}, 2'b11);
            if (!sram_ce_n && !sram_we_n) begin
                wlow++;
                chk(sram_oe_n, "R1", "oe high during write", sram_oe_n, 1);
                p_addr = sram_addr;
                p_mask = 2'b00;
                for (int i = 0; i < 2; i++) begin
                    if (!sram_be_n[i]) begin
                        if (!dq_oe[i]) chk(1'b0, "R2", "selected lane not driven", dq_oe, 2'b11);
                        p_data[8*i +: 8] = dq_out[8*i +: 8];
                        p_mask[i] = 1'b1;
                    end else if (dq_oe[i]) begin
                        chk(1'b0, "R2", "unselected lane driven", dq_oe, 0);
                    end
                end
            end else if (wlow > 0) begin
                chk(wlow >= 2, "R1", "write pulse cycles", wlow, 2);
                chk(dq_oe == 2'b00, "R5", "driver after we rise", dq_oe, 0);
                w = mem_rd(p_addr);
                for (int i = 0; i < 2; i++)
                    if (p_mask[i]) w[8*i +: 8] = p_data[8*i +: 8];
                mem_m[p_addr] = w;
                wlow = 0;
            end
            if (!sram_ce_n && sram_we_n && !sram_oe_n) rdc++;
            else rdc = 0;
            if (rdc >= 3) begin
                w = mem_rd(sram_addr);
                for (int i = 0; i < 2; i++)
                    dq_in[8*i +: 8] = !sram_be_n[i] ? w[8*i +: 8] : 8'hEE;
            end else begin
                dq_in = 16'hDEAD;
            end
            prev_oe_n = sram_oe_n;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          is_wr;
        logic [15:0] exp;
        int          start;
        int          lat;
        string       tag;
    } item_t;
    item_t exp_q[$];

    logic prev_ready = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            item_t it;
            if (ready) begin
                chk(!prev_ready, "R8", "ready longer than one cycle", prev_ready, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "ready without request", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(cyc - it.start == it.lat, it.tag, "latency", cyc - it.start, it.lat);
                    if (!it.is_wr)
                        chk(rdata == it.exp, it.is_wr ? "R1" : "R3", "read data", rdata, it.exp);
                end
            end
            prev_ready = ready;
        end
    end

    bit last_was_wr = 0;

    task automatic op(input bit w, input int a, input logic [15:0] d,
                      input logic [1:0] s, input int gap, input string tag);
        item_t it;
        logic [15:0] r;
        repeat (gap + 1) @(negedge clk);
        r = ref_rd(a);
        it.is_wr = w;
        it.start = cyc;
        it.tag   = tag;
        it.exp   = {s[1] ? r[15:8] : 8'h00, s[0] ? r[7:0] : 8'h00};
        it.lat   = w ? 4 : ((last_was_wr && gap == 0) ? 5 : 4);
        if (w) begin
            for (int i = 0; i < 2; i++)
                if (s[i]) r[8*i +: 8] = d[8*i +: 8];
            ref_m[a] = r;
        end
        exp_q.push_back(it);
        req = 1'b1; wr = w; addr = 18'(a); wdata = d; bsel = s;
        do @(negedge clk); while (!ready);
        req = 1'b0;
        last_was_wr = w;
    endtask

    task automatic idle_check(input string tag);
        chk(sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11 && dq_oe == 2'b00,
            tag, "strobes inactive", {sram_ce_n, sram_we_n, sram_oe_n, sram_be_n, dq_oe}, 7'h7C);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!finished) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog expired actual=hung expected=done");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        logic [15:0] lf;
        rst = 1'b1; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; bsel = '0;
        repeat (3) @(negedge clk);
        idle_check("R9");
        chk(!ready, "R9", "ready low in reset", ready, 0);
        rst = 1'b0;
        @(negedge clk);
        idle_check("R9");
        chk(!ready, "R9", "ready low after reset", ready, 0);

        // R1 full-word write, R3 read after an idle gap
        op(1, 18'h00010, 16'h1234, 2'b11, 1, "R1");
        op(0, 18'h00010, 16'h0000, 2'b11, 1, "R3");
        // R2 low-byte write, R6 read immediately after
        op(1, 18'h00010, 16'hFFAB, 2'b01, 1, "R2");
        op(0, 18'h00010, 16'h0000, 2'b11, 0, "R6");
        // R2 high-byte write at top address, R6 read after an idle gap
        op(1, 18'h3FFFF, 16'hCD55, 2'b10, 0, "R2");
        op(0, 18'h3FFFF, 16'h0000, 2'b11, 1, "R6");
        // R4 partial reads
        op(0, 18'h00010, 16'h0000, 2'b01, 0, "R4");
        op(0, 18'h00010, 16'h0000, 2'b10, 0, "R4");
        op(0, 18'h00010, 16'h0000, 2'b00, 0, "R4");
        // R2 write with no byte selected changes nothing
        op(1, 18'h00010, 16'h0F0F, 2'b00, 1, "R2");
        op(0, 18'h00010, 16'h0000, 2'b11, 0, "R6");
        // R7 standby while idle
        repeat (3) begin
            @(negedge clk);
            idle_check("R7");
        end
        // mixed traffic
        lf = 16'hACE1;
        for (int k = 0; k < 24; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(lf[0], 32'(lf[3:1]) + 18'h00100, lf ^ 16'h9C31, lf[5:4], int'(lf[6]),
               lf[0] ? "R2" : "R3");
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "outstanding items", exp_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule